// File: doc/BRIEF.md
# Keyed configuration item read port

This block gives a host a small store of byte-string configuration items. Every item is named by a 16-bit key. The host writes a key to choose an item. It then pulls the item's bytes in order through a data access that may be 1 to `MAX_BYTES` bytes wide. The port keeps the chosen key and a byte cursor into the item. A wide read packs the bytes it consumes with the earliest byte in the most significant lane, and it fills with zeros once the item is used up.

Item bytes and lengths sit in local storage. A separate load port fills this storage before the host starts its accesses. Two items are fixed in logic and cannot be loaded: a 4-byte ASCII signature at key 0 and a version word at key 1. A parameter chooses how accesses are decoded. In the split variant the selector and the data have their own addresses. In the combined variant they share one address, and the access size decides which one an access reaches.

Top module: `keyed_cfg_port`

## Requirements
- R1: After reset, key 0 is selected with the cursor at zero. A 4-byte read then returns the signature, first character most significant: 0x43464750 ("CFGP"). While in reset, rd_data, rd_valid and acc_err are all zero.
- R2: A selector write sets the cursor back to zero every time, even when the same key is written again.
- R3: The item index is key bits 13:0. Bit 14 is ignored. An index at or above FILE_BASE+FILE_SLOTS marks the selection invalid.
- R4: Key bit 15 chooses a second bank of items that uses the same index space as the first.
- R5: A read of N bytes puts the byte at the cursor in bits [8N-1:8N-8], the next byte one lane lower, and so on. Bits at and above 8N are zero. The cursor moves forward by the number of bytes consumed.
- R6: When fewer than N bytes are left, the lanes below the last byte consumed are zero and the cursor stops at the item length.
- R7: A read returns zero and leaves the cursor where it is when the selection is invalid, the item is empty, or the cursor is at the item length.
- R8: A data write is accepted without error. It changes no item byte and moves no cursor.
- R9: Key 1 in bank 0 is a 4-byte little-endian version word. Bit 0 of this word is always 1, and bit 1 equals DMA_EN. With DMA_EN=1 a 4-byte read gives 0x03000000.
- R10: Combined variant (COMBINED=1). The port lives at acc_addr 0. A 1-byte read is a data read, a 1-byte write is a data write, and a 2-byte write is a selector write. Every other size, and any access to acc_addr 1, is rejected.
- R11: Split variant. acc_addr 0 is the selector and takes only 2-byte writes. acc_addr 1 is data and takes sizes 1 to MAX_BYTES. Anything else is rejected. A rejected access reads as zero and changes no state.
- R12: rd_valid pulses one cycle after every read access, whether accepted or rejected. acc_err pulses one cycle after every rejected access, and on that cycle rd_data is zero.
- R13: A load with ld_is_len=1 sets an item length, clamped to ITEM_BYTES. A load with ld_is_len=0 writes one byte. Loads aimed at bank 0 keys 0 and 1 are ignored. A host read in the same cycle as a load sees the contents from before the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Host access strobe |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_addr | input | 1 | Split: 0 selector, 1 data. Combined: must be 0 |
| acc_size | input | SIZE_W | Access size in bytes |
| acc_wdata | input | 16 | Key for selector writes; ignored for data writes |
| rd_data | output | 8*MAX_BYTES | Packed read result, low 8N bits used |
| rd_valid | output | 1 | Read result strobe |
| acc_err | output | 1 | Rejected-access strobe |
| ld_en | input | 1 | Load strobe |
| ld_is_len | input | 1 | 1 writes a length entry, 0 writes a data byte |
| ld_bank | input | 1 | Target bank |
| ld_index | input | IDX_W | Target item index |
| ld_byte | input | BYTE_W | Byte position inside the item |
| ld_value | input | 8 | Byte value or length |

## Verification
The two functions that can fall in the same cycle are a load-port write and a host data read aimed at the same item. The bench selects an empty item. In a single cycle it then issues a 1-byte read together with a load that sets that item's length to 3. The read must return zero, because it still sees the old length. The next read must return the item's first stored byte, because the new length is then in place.

// File: rtl/kcfg_pkg.sv
package kcfg_pkg;
   localparam int KEY_W    = 16;
   localparam int BANK_BIT = 15;
   localparam int INDEX_W  = 14;

   typedef enum logic [2:0] {
      OP_IDLE   = 3'd0,
      OP_SELECT = 3'd1,
      OP_READ   = 3'd2,
      OP_DWRITE = 3'd3,
      OP_REJECT = 3'd4
   } op_e;
endpackage

// File: rtl/kcfg_decode.sv
module kcfg_decode
   import kcfg_pkg::*;
#(
   parameter int COMBINED  = 0,
   parameter int MAX_BYTES = 8,
   parameter int SIZE_W    = 4
) (
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic              acc_addr,
   input  logic [SIZE_W-1:0] acc_size,
   output op_e               op
);
   localparam logic [SIZE_W-1:0] SZ_ONE = SIZE_W'(1);
   localparam logic [SIZE_W-1:0] SZ_TWO = SIZE_W'(2);
   localparam logic [SIZE_W-1:0] SZ_MAX = SIZE_W'(MAX_BYTES);

   generate
      if (COMBINED != 0) begin : g_comb
         // one address; the access size picks selector or data
         always_comb begin
            op = OP_IDLE;
            if (acc_valid) begin
               if (acc_addr)
                  op = OP_REJECT;
               else if (acc_size == SZ_ONE)
                  op = acc_write ? OP_DWRITE : OP_READ;
               else if (acc_size == SZ_TWO && acc_write)
                  op = OP_SELECT;
               else
                  op = OP_REJECT;
            end
         end
      end else begin : g_split
         logic size_ok;
         assign size_ok = (acc_size != '0) && (acc_size <= SZ_MAX);
         always_comb begin
            op = OP_IDLE;
            if (acc_valid) begin
               if (!acc_addr)
                  op = (acc_write && acc_size == SZ_TWO) ? OP_SELECT : OP_REJECT;
               else if (!size_ok)
                  op = OP_REJECT;
               else
                  op = acc_write ? OP_DWRITE : OP_READ;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/kcfg_store.sv
module kcfg_store
   import kcfg_pkg::*;
#(
   parameter int          LIMIT      = 8,
   parameter int          ITEM_BYTES = 16,
   parameter int          MAX_BYTES  = 8,
   parameter logic [31:0] SIGNATURE  = 32'h43464750,
   parameter int          DMA_EN     = 1,
   localparam int IDX_W  = $clog2(LIMIT),
   localparam int BYTE_W = $clog2(ITEM_BYTES),
   localparam int OFF_W  = $clog2(ITEM_BYTES + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   ld_en,
   input  logic                   ld_is_len,
   input  logic                   ld_bank,
   input  logic [IDX_W-1:0]       ld_index,
   input  logic [BYTE_W-1:0]      ld_byte,
   input  logic [7:0]             ld_value,
   input  logic                   rd_bank,
   input  logic [INDEX_W-1:0]     rd_index,
   input  logic [OFF_W-1:0]       rd_off,
   output logic [MAX_BYTES*8-1:0] rd_bytes,
   output logic [OFF_W-1:0]       rd_len
);
   localparam int SLOTS  = 2 * LIMIT;
   localparam int SLOT_W = $clog2(SLOTS);
   localparam int DEPTH  = SLOTS * ITEM_BYTES;
   localparam int AW     = $clog2(DEPTH);
   localparam logic [7:0] VERSION = 8'(1 | ((DMA_EN != 0) ? 2 : 0));

   logic [7:0]       mem     [DEPTH];
   logic [OFF_W-1:0] len_tab [SLOTS];

   // load side
   logic              ld_in, ld_fixed;
   logic [SLOT_W-1:0] ld_slot;
   logic [OFF_W-1:0]  ld_len_clamped;

   assign ld_in    = {1'b0, ld_index} < (IDX_W + 1)'(LIMIT);
   assign ld_fixed = !ld_bank && ({1'b0, ld_index} < (IDX_W + 1)'(2));
   assign ld_slot  = SLOT_W'(ld_bank ? LIMIT : 0) + SLOT_W'(ld_index);
   assign ld_len_clamped = (int'(ld_value) > ITEM_BYTES) ? OFF_W'(ITEM_BYTES)
                                                         : OFF_W'(ld_value);

   always_ff @(posedge clk) begin
      if (ld_en && !ld_is_len && ld_in && !ld_fixed)
         mem[AW'(int'(ld_slot) * ITEM_BYTES + int'(ld_byte))] <= ld_value;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < SLOTS; k++) len_tab[k] <= '0;
      end else if (ld_en && ld_is_len && ld_in && !ld_fixed) begin
         len_tab[ld_slot] <= ld_len_clamped;
      end
   end

   // gather side: bytes rd_off .. rd_off+MAX_BYTES-1 of the chosen item
   logic rd_ok, fix_sig, fix_ver;
   int   rd_slot;

   assign rd_ok   = int'(rd_index) < LIMIT;
   assign fix_sig = !rd_bank && (rd_index == INDEX_W'(0));
   assign fix_ver = !rd_bank && (rd_index == INDEX_W'(1));
   assign rd_slot = (rd_bank ? LIMIT : 0) + int'(rd_index);

   always_comb begin
      if (fix_sig || fix_ver) rd_len = OFF_W'(4);
      else if (rd_ok)         rd_len = len_tab[SLOT_W'(rd_slot)];
      else                    rd_len = '0;
   end

   always_comb begin
      rd_bytes = '0;
      for (int j = 0; j < MAX_BYTES; j++) begin
         int p;
         p = int'(rd_off) + j;
         if (fix_sig) begin
            if (p < 4) rd_bytes[8*j +: 8] = 8'(SIGNATURE >> (8 * (3 - p)));
         end else if (fix_ver) begin
            if (p == 0) rd_bytes[8*j +: 8] = VERSION;
         end else if (rd_ok && p < ITEM_BYTES) begin
            rd_bytes[8*j +: 8] = mem[AW'(rd_slot * ITEM_BYTES + p)];
         end
      end
   end
endmodule

// File: rtl/kcfg_cursor.sv
module kcfg_cursor
   import kcfg_pkg::*;
#(
   parameter int LIMIT      = 8,
   parameter int ITEM_BYTES = 16,
   parameter int MAX_BYTES  = 8,
   parameter int SIZE_W     = 4,
   localparam int OFF_W  = $clog2(ITEM_BYTES + 1),
   localparam int DATA_W = MAX_BYTES * 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  op_e                op,
   input  logic [KEY_W-1:0]   sel_key,
   input  logic [SIZE_W-1:0]  rd_size,
   input  logic [DATA_W-1:0]  item_bytes,
   input  logic [OFF_W-1:0]   item_len,
   output logic               cur_bank,
   output logic [INDEX_W-1:0] cur_index,
   output logic [OFF_W-1:0]   cur_off,
   output logic [DATA_W-1:0]  rd_data
);
   logic               bank_q, ok_q;
   logic [INDEX_W-1:0] idx_q;
   logic [OFF_W-1:0]   off_q;
   logic               unused_key_bit;

   assign unused_key_bit = sel_key[INDEX_W];
   assign cur_bank  = bank_q;
   assign cur_index = idx_q;
   assign cur_off   = off_q;

   // pack: earliest byte into the highest used lane, zero fill below
   logic [DATA_W-1:0] pack_val;
   int                take_cnt;
   int                n_bytes;

   always_comb begin
      n_bytes  = int'(rd_size);
      pack_val = '0;
      take_cnt = 0;
      for (int j = 0; j < MAX_BYTES; j++) begin
         if (j < n_bytes && ok_q && (int'(off_q) + j) < int'(item_len)) begin
            pack_val = pack_val | (DATA_W'(item_bytes[8*j +: 8]) << (8 * (n_bytes - 1 - j)));
            take_cnt = take_cnt + 1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bank_q  <= 1'b0;
         idx_q   <= '0;
         ok_q    <= 1'b1;
         off_q   <= '0;
         rd_data <= '0;
      end else begin
         rd_data <= (op == OP_READ) ? pack_val : '0;
         if (op == OP_SELECT) begin
            bank_q <= sel_key[BANK_BIT];
            idx_q  <= sel_key[INDEX_W-1:0];
            ok_q   <= int'(sel_key[INDEX_W-1:0]) < LIMIT;
            off_q  <= '0;
         end else if (op == OP_READ) begin
            off_q <= off_q + OFF_W'(take_cnt);
         end
      end
   end

   assert_select_rewinds_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_SELECT) |=> (off_q == '0));

   assert_read_advances_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_READ && ok_q && off_q < item_len) |=> (off_q > $past(off_q)));

   assert_off_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      off_q <= OFF_W'(ITEM_BYTES));

   assert_hold_exhausted_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_READ && (!ok_q || off_q >= item_len)) |=> ($stable(off_q) && rd_data == '0));

   assert_dwrite_inert_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_DWRITE) |=> ($stable(off_q) && $stable(idx_q) && $stable(bank_q)));

   assert_reject_inert_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_REJECT) |=> ($stable(off_q) && $stable(idx_q) && $stable(bank_q) && rd_data == '0));
endmodule

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port
   import kcfg_pkg::*;
#(
   parameter int          FILE_BASE  = 4,
   parameter int          FILE_SLOTS = 4,
   parameter int          ITEM_BYTES = 16,
   parameter int          MAX_BYTES  = 8,
   parameter int          COMBINED   = 0,
   parameter logic [31:0] SIGNATURE  = 32'h43464750,
   parameter int          DMA_EN     = 1,
   localparam int LIMIT  = FILE_BASE + FILE_SLOTS,
   localparam int IDX_W  = $clog2(LIMIT),
   localparam int BYTE_W = $clog2(ITEM_BYTES),
   localparam int SIZE_W = $clog2(MAX_BYTES + 1),
   localparam int DATA_W = MAX_BYTES * 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic              acc_addr,
   input  logic [SIZE_W-1:0] acc_size,
   input  logic [KEY_W-1:0]  acc_wdata,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              acc_err,
   input  logic              ld_en,
   input  logic              ld_is_len,
   input  logic              ld_bank,
   input  logic [IDX_W-1:0]  ld_index,
   input  logic [BYTE_W-1:0] ld_byte,
   input  logic [7:0]        ld_value
);
   localparam int OFF_W = $clog2(ITEM_BYTES + 1);

   generate
      if (LIMIT < 2 || LIMIT > (1 << INDEX_W)) begin : g_bad_limit
         $error("index limit out of range");
      end
      if (ITEM_BYTES < 4 || ITEM_BYTES > 255 || (ITEM_BYTES & (ITEM_BYTES - 1)) != 0) begin : g_bad_item
         $error("ITEM_BYTES must be a power of two from 4 to 128");
      end
      if (MAX_BYTES < 2 || MAX_BYTES > 8) begin : g_bad_width
         $error("MAX_BYTES must be 2 to 8");
      end
   endgenerate

   op_e                op;
   logic               cur_bank;
   logic [INDEX_W-1:0] cur_index;
   logic [OFF_W-1:0]   cur_off;
   logic [DATA_W-1:0]  item_bytes;
   logic [OFF_W-1:0]   item_len;

   kcfg_decode #(.COMBINED(COMBINED), .MAX_BYTES(MAX_BYTES), .SIZE_W(SIZE_W)) u_decode (
      .acc_valid (acc_valid),
      .acc_write (acc_write),
      .acc_addr  (acc_addr),
      .acc_size  (acc_size),
      .op        (op)
   );

   kcfg_store #(
      .LIMIT(LIMIT), .ITEM_BYTES(ITEM_BYTES), .MAX_BYTES(MAX_BYTES),
      .SIGNATURE(SIGNATURE), .DMA_EN(DMA_EN)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld_en     (ld_en),
      .ld_is_len (ld_is_len),
      .ld_bank   (ld_bank),
      .ld_index  (ld_index),
      .ld_byte   (ld_byte),
      .ld_value  (ld_value),
      .rd_bank   (cur_bank),
      .rd_index  (cur_index),
      .rd_off    (cur_off),
      .rd_bytes  (item_bytes),
      .rd_len    (item_len)
   );

   kcfg_cursor #(
      .LIMIT(LIMIT), .ITEM_BYTES(ITEM_BYTES), .MAX_BYTES(MAX_BYTES), .SIZE_W(SIZE_W)
   ) u_cursor (
      .clk        (clk),
      .rst_n      (rst_n),
      .op         (op),
      .sel_key    (acc_wdata),
      .rd_size    (acc_size),
      .item_bytes (item_bytes),
      .item_len   (item_len),
      .cur_bank   (cur_bank),
      .cur_index  (cur_index),
      .cur_off    (cur_off),
      .rd_data    (rd_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         acc_err  <= 1'b0;
      end else begin
         rd_valid <= acc_valid && !acc_write;
         acc_err  <= (op == OP_REJECT);
      end
   end

   assert_err_zero_data_R12: assert property (@(posedge clk) disable iff (!rst_n)
      acc_err |-> (rd_data == '0));

   assert_result_follows_access_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid || acc_err) |-> $past(acc_valid));
endmodule

// File: tb/keyed_cfg_port_test.sv
module keyed_cfg_port_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   // shared load bus
   logic       ld_en = 0, ld_is_len = 0, ld_bank = 0;
   logic [2:0] ld_index = '0;
   logic [3:0] ld_byte = '0;
   logic [7:0] ld_value = '0;

   // split-variant host side
   logic        a_valid = 0, a_write = 0, a_addr = 0;
   logic [3:0]  a_size = '0;
   logic [15:0] a_wdata = '0;
   logic [63:0] a_rdata;
   logic        a_rvalid, a_err;

   // combined-variant host side
   logic        c_valid = 0, c_write = 0, c_addr = 0;
   logic [3:0]  c_size = '0;
   logic [15:0] c_wdata = '0;
   logic [63:0] c_rdata;
   logic        c_rvalid, c_err;

   keyed_cfg_port #(.COMBINED(0)) uut (
      .clk(clk), .rst_n(rst_n), .acc_valid(a_valid), .acc_write(a_write), .acc_addr(a_addr),
      .acc_size(a_size), .acc_wdata(a_wdata), .rd_data(a_rdata), .rd_valid(a_rvalid),
      .acc_err(a_err), .ld_en(ld_en), .ld_is_len(ld_is_len), .ld_bank(ld_bank),
      .ld_index(ld_index), .ld_byte(ld_byte), .ld_value(ld_value));

   keyed_cfg_port #(.COMBINED(1)) uut_c (
      .clk(clk), .rst_n(rst_n), .acc_valid(c_valid), .acc_write(c_write), .acc_addr(c_addr),
      .acc_size(c_size), .acc_wdata(c_wdata), .rd_data(c_rdata), .rd_valid(c_rvalid),
      .acc_err(c_err), .ld_en(ld_en), .ld_is_len(ld_is_len), .ld_bank(ld_bank),
      .ld_index(ld_index), .ld_byte(ld_byte), .ld_value(ld_value));

   // ---------------- reference model ----------------
   function automatic logic [7:0] byte_of(int b, int i, int j);
      return 8'((b * 128 + i * 16 + j) ^ 32'h5A);
   endfunction

   function automatic int raw_len(int b, int i);
      if (b == 0 && i == 7) return 0;
      if (b == 1 && i == 7) return 40;
      return (i * 3 + b * 5) % 19;
   endfunction

   function automatic int mlen(int b, int i);
      if (b == 0 && i < 2) return 4;
      return (raw_len(b, i) > 16) ? 16 : raw_len(b, i);
   endfunction

   function automatic logic [7:0] mbyte(int b, int i, int p);
      if (b == 0 && i == 0) return 8'(32'h43464750 >> (8 * (3 - p)));
      if (b == 0 && i == 1) return (p == 0) ? 8'h03 : 8'h00;
      return byte_of(b, i, p);
   endfunction

   int m_bank = 0, m_idx = 0, m_off = 0;
   bit m_ok = 1;

   function automatic void msel(int key);
      m_bank = (key >> 15) & 1;
      m_idx  = key & 16'h3FFF;
      m_ok   = (m_idx < 8);
      m_off  = 0;
   endfunction

   function automatic logic [63:0] mread(int n);
      logic [63:0] v = '0;
      if (!m_ok) return v;
      for (int j = 0; j < n; j++) begin
         if (m_off < mlen(m_bank, m_idx)) begin
            v = v | (64'(mbyte(m_bank, m_idx, m_off)) << (8 * (n - 1 - j)));
            m_off++;
         end
      end
      return v;
   endfunction

   // ---------------- helpers ----------------
   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic host_op(bit w, bit ad, int sz, logic [15:0] wd);
      a_valid = 1; a_write = w; a_addr = ad; a_size = 4'(sz); a_wdata = wd;
      @(negedge clk);
      a_valid = 0; a_write = 0;
   endtask

   task automatic c_op(bit w, bit ad, int sz, logic [15:0] wd);
      c_valid = 1; c_write = w; c_addr = ad; c_size = 4'(sz); c_wdata = wd;
      @(negedge clk);
      c_valid = 0; c_write = 0;
   endtask

   task automatic sel(int key);
      host_op(1, 0, 2, 16'(key));
      msel(key);
   endtask

   task automatic rd(int n);
      host_op(0, 1, n, 16'h0);
   endtask

   task automatic load(bit is_len, int b, int i, int byt, int val);
      ld_en = 1; ld_is_len = is_len; ld_bank = b[0]; ld_index = 3'(i);
      ld_byte = 4'(byt); ld_value = 8'(val);
      @(negedge clk);
      ld_en = 0;
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs quiet while in reset
      chk("R1 reset rd_data", a_rdata, 64'h0);
      chk("R1 reset rd_valid", 64'(a_rvalid), 64'h0);
      chk("R1 reset acc_err", 64'(a_err), 64'h0);
      rst_n = 1;
      @(negedge clk);

      // R1: signature selected out of reset
      rd(4);
      chk("R1 signature", a_rdata, 64'h43464750);
      chk("R12 rd_valid after read", 64'(a_rvalid), 64'h1);
      chk("R12 no err on good read", 64'(a_err), 64'h0);
      c_op(0, 0, 1, 16'h0); chk("R10 comb byte0", c_rdata, 64'h43);
      c_op(0, 0, 1, 16'h0); chk("R10 comb byte1", c_rdata, 64'h46);
      c_op(0, 0, 1, 16'h0); chk("R10 comb byte2", c_rdata, 64'h47);
      c_op(0, 0, 1, 16'h0); chk("R10 comb byte3", c_rdata, 64'h50);

      // R13: load everything, including attempts at the fixed items
      for (int b = 0; b < 2; b++)
         for (int i = 0; i < 8; i++) begin
            load(1, b, i, 0, raw_len(b, i));
            for (int j = 0; j < 16; j++) load(0, b, i, j, byte_of(b, i, j));
         end

      // sweep every item with every read width
      for (int b = 0; b < 2; b++)
         for (int i = 0; i < 8; i++)
            for (int n = 1; n <= 8; n++) begin
               sel(b * 32768 + i);
               chk("R12 select no rd_valid", 64'(a_rvalid), 64'h0);
               for (int r = 0; r < mlen(b, i) / n + 2; r++) begin
                  string tag;
                  logic [63:0] e;
                  if (b == 0 && i < 2) tag = "R13 fixed item";
                  else if (m_off >= mlen(b, i)) tag = "R7 exhausted";
                  else if (mlen(b, i) - m_off < n) tag = "R6 partial";
                  else tag = "R5 full";
                  e = mread(n);
                  rd(n);
                  chk(tag, a_rdata, e);
               end
            end

      // R9 version word
      sel(1); rd(4); chk("R9 version", a_rdata, 64'h03000000);

      // R4 second bank, same index
      sel(16'h8002); rd(2);
      chk("R4 bank1 idx2", a_rdata, {48'h0, byte_of(1, 2, 0), byte_of(1, 2, 1)});

      // R2 reselect rewinds
      sel(16'h8002); rd(4);
      sel(16'h8002); rd(4);
      chk("R2 rewind", a_rdata, {32'h0, byte_of(1, 2, 0), byte_of(1, 2, 1),
                                  byte_of(1, 2, 2), byte_of(1, 2, 3)});

      // R3 index field and limit
      sel(16'h0008); rd(8); chk("R3 index at limit", a_rdata, 64'h0);
      chk("R12 rd_valid on invalid key", 64'(a_rvalid), 64'h1);
      sel(16'h3FFF); rd(8); chk("R3 max index", a_rdata, 64'h0);
      sel(16'h8008); rd(8); chk("R3 bank1 at limit", a_rdata, 64'h0);
      sel(16'h4002); rd(2);
      chk("R3 bit14 ignored", a_rdata, {48'h0, byte_of(0, 2, 0), byte_of(0, 2, 1)});

      // R6 short item fills low lanes with zero
      sel(16'h8005); rd(8); chk("R6 one byte item", a_rdata, {byte_of(1, 5, 0), 56'h0});

      // R13 clamp: length 40 becomes 16
      sel(16'h8007); rd(8); rd(8); rd(8);
      chk("R13 clamp to item size", a_rdata, 64'h0);

      // R11 rejects in the split variant, R8 data write
      sel(3); rd(2);
      chk("R5 two bytes", a_rdata, {48'h0, byte_of(0, 3, 0), byte_of(0, 3, 1)});
      host_op(0, 0, 2, 16'h0);
      chk("R11 selector read err", 64'(a_err), 64'h1);
      chk("R12 err zero data", a_rdata, 64'h0);
      host_op(1, 0, 1, 16'h0005);
      chk("R11 short selector write err", 64'(a_err), 64'h1);
      host_op(0, 1, 0, 16'h0);
      chk("R11 size zero err", 64'(a_err), 64'h1);
      host_op(0, 1, 9, 16'h0);
      chk("R11 oversize err", 64'(a_err), 64'h1);
      rd(1); chk("R11 state kept", a_rdata, 64'(byte_of(0, 3, 2)));
      host_op(1, 1, 4, 16'hFFFF);
      chk("R8 data write no err", 64'(a_err), 64'h0);
      rd(1); chk("R8 cursor kept", a_rdata, 64'(byte_of(0, 3, 3)));

      // R10 combined decode
      c_op(1, 0, 2, 16'h0003);
      chk("R10 comb select no err", 64'(c_err), 64'h0);
      c_op(0, 0, 1, 16'h0); chk("R10 comb data", c_rdata, 64'(byte_of(0, 3, 0)));
      c_op(0, 0, 2, 16'h0);
      chk("R10 comb 2-byte read err", 64'(c_err), 64'h1);
      chk("R10 comb rejected data", c_rdata, 64'h0);
      c_op(1, 0, 4, 16'h0001);
      chk("R10 comb 4-byte write err", 64'(c_err), 64'h1);
      c_op(0, 1, 1, 16'h0);
      chk("R10 comb addr1 err", 64'(c_err), 64'h1);
      c_op(0, 0, 1, 16'h0); chk("R10 comb state kept", c_rdata, 64'(byte_of(0, 3, 1)));
      c_op(1, 0, 1, 16'h00AA);
      chk("R10 comb data write no err", 64'(c_err), 64'h0);
      c_op(0, 0, 1, 16'h0); chk("R10 comb after write", c_rdata, 64'(byte_of(0, 3, 2)));

      // R13 load and read in the same cycle
      sel(7); rd(1); chk("R7 empty item", a_rdata, 64'h0);
      ld_en = 1; ld_is_len = 1; ld_bank = 0; ld_index = 3'd7; ld_byte = '0; ld_value = 8'd3;
      a_valid = 1; a_write = 0; a_addr = 1; a_size = 4'd1;
      @(negedge clk);
      ld_en = 0; a_valid = 0;
      chk("R13 same-cycle read sees old length", a_rdata, 64'h0);
      rd(1); chk("R13 new length visible", a_rdata, 64'(byte_of(0, 7, 0)));

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule